// File: doc/BRIEF.md
# Lockable pad attribute controller

This block keeps one attribute word for each I/O pad of a chip and applies two of its bits to the pad signals as they pass through. There are two groups of pads: a small set of fixed-function pads and a larger set of multiplexed pads. Both groups share one flat pad index, with the fixed pads first. Software reaches the attribute words and a single global lock bit over a simple word-wide register bus. Each access is a one-cycle request, and the response arrives in the following cycle.

Each pad sits between the core-side output, output-enable and input signals and the pad-side signals. One attribute bit inverts the signal polarity in both directions. A second bit turns the pad into an emulated open-drain driver, which only ever pulls the pad low. The lock bit starts out set. Software can clear it but cannot set it again. Once it is clear, the attribute words are frozen until the next reset. Accesses to offsets outside the map raise a one-cycle error flag.

Top module: `pad_attr_ctrl`

## Requirements
- R1: After synchronous reset the lock bit is 1, every attribute word is 0, and `rsp_rdata` and `rsp_err` are 0.
- R2: The lock register is at byte offset 0x0 and reads as 1 in bit 0 and zeros elsewhere. A write with data bit 0 equal to 0 clears it. A write with data bit 0 equal to 1 leaves it unchanged, so only reset can set it again.
- R3: The attribute word of pad p is at byte offset 4*(p+1). Fixed pads are p = 0..3 and multiplexed pad m is p = 4+m. A write stores data bits 5:0 and ignores the higher bits. A read returns the stored 6 bits zero-extended.
- R4: While the lock bit is 0, writes to attribute words are dropped without an error, and reads still return the stored values.
- R5: Read data appears on `rsp_rdata` in the cycle after the request. In every cycle that does not follow a read, `rsp_rdata` is 0.
- R6: An offset is unmapped if its low two bits are nonzero or its word index exceeds 22. An access to an unmapped offset raises `rsp_err` for exactly the next cycle, returns 0 on `rsp_rdata`, and changes no state. Mapped accesses never raise `rsp_err`.
- R7: Attribute bit 0 (invert) gives `pad_out = core_out ^ bit0` and `core_in = pad_in ^ bit0`. When bit 1 is 0, `pad_oe` equals `core_oe`.
- R8: Attribute bit 1 (open drain) works on the value v = `core_out ^ bit0`. It sets `pad_out` to 0 and `pad_oe` to `core_oe & ~v`, so the pad is driven only while v is low and is never driven high.
- R9: Attribute bits 5:2 have no effect on any pad signal.
- R10: The pad paths are combinational. A new attribute value takes effect in the cycle after the write request is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Bus request valid for one cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 8 | Byte offset |
| req_wdata | input | 32 | Write data |
| rsp_rdata | output | 32 | Read data, one cycle after a read request |
| rsp_err | output | 1 | Unmapped-offset error pulse |
| core_out | input | 22 | Core output value per pad |
| core_oe | input | 22 | Core output enable per pad |
| core_in | output | 22 | Input value returned to the core per pad |
| pad_out | output | 22 | Value driven towards each pad |
| pad_oe | output | 22 | Drive enable towards each pad |
| pad_in | input | 22 | Value sampled from each pad |

## Verification
The bench reads every byte offset from 0x00 to 0xFF. A decoder that let a misaligned offset alias onto a register, or that was off by one at the last multiplexed pad, would return data or miss the error flag there. A misaligned write with bit 0 clear is aimed at the lock register, so an aliasing decoder would wrongly lock the bank. For each invert/open-drain combination, the bench sweeps all eight combinations of core output, enable and pad input on every pad. An open-drain path that ignored inversion would drive or release the pad in the wrong phase. Once the bank is locked, the bench writes 1 to the lock bit and rewrites attributes. A lock that could be set again, or a gate that leaked writes, would show up in the readback and on the pads.

// File: rtl/pad_attr_pkg.sv
package pad_attr_pkg;
  typedef enum logic [1:0] {
    SEL_NONE = 2'd0,
    SEL_LOCK = 2'd1,
    SEL_ATTR = 2'd2
  } sel_e;

  localparam int INV_BIT = 0;
  localparam int OD_BIT  = 1;
endpackage

// File: rtl/pad_attr_decode.sv
module pad_attr_decode
  import pad_attr_pkg::*;
#(
  parameter int ADDR_W   = 8,
  parameter int NUM_PADS = 22,
  parameter int IDX_W    = $clog2(NUM_PADS)
) (
  input  logic [ADDR_W-1:0] addr,
  output sel_e              sel,
  output logic [IDX_W-1:0]  idx
);
  localparam int WORD_W = ADDR_W - 2;

  logic [WORD_W-1:0] word;
  logic [WORD_W-1:0] word_m1;

  assign word    = addr[ADDR_W-1:2];
  assign word_m1 = word - WORD_W'(1);
  assign idx     = word_m1[IDX_W-1:0];

  always_comb begin
    if (addr[1:0] != 2'b00) begin
      sel = SEL_NONE;
    end else if (word == '0) begin
      sel = SEL_LOCK;
    end else if (word <= WORD_W'(NUM_PADS)) begin
      sel = SEL_ATTR;
    end else begin
      sel = SEL_NONE;
    end
  end
endmodule

// File: rtl/pad_attr_regs.sv
module pad_attr_regs
  import pad_attr_pkg::*;
#(
  parameter int NUM_PADS = 22,
  parameter int ATTR_W   = 6,
  parameter int DATA_W   = 32,
  parameter int ADDR_W   = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                req_valid,
  input  logic                req_write,
  input  logic [ADDR_W-1:0]   req_addr,
  input  logic [DATA_W-1:0]   req_wdata,
  output logic [DATA_W-1:0]   rsp_rdata,
  output logic                rsp_err,
  output logic [NUM_PADS-1:0] inv_o,
  output logic [NUM_PADS-1:0] od_o
);
  localparam int IDX_W = $clog2(NUM_PADS);

  sel_e                            sel;
  logic [IDX_W-1:0]                idx;
  logic                            wen_q;
  logic [NUM_PADS-1:0][ATTR_W-1:0] attr_q;
  logic                            hit_none;
  logic                            do_rd;
  logic                            do_wr;
  logic                            wdata_unused;

  assign wdata_unused = ^req_wdata[DATA_W-1:ATTR_W];

  pad_attr_decode #(
    .ADDR_W  (ADDR_W),
    .NUM_PADS(NUM_PADS),
    .IDX_W   (IDX_W)
  ) u_dec (
    .addr(req_addr),
    .sel (sel),
    .idx (idx)
  );

  assign hit_none = req_valid && (sel == SEL_NONE);
  assign do_rd    = req_valid && !req_write;
  assign do_wr    = req_valid && req_write;

  always_ff @(posedge clk) begin
    if (rst) begin
      wen_q     <= 1'b1;
      attr_q    <= '0;
      rsp_rdata <= '0;
      rsp_err   <= 1'b0;
    end else begin
      rsp_err   <= hit_none;
      rsp_rdata <= '0;
      if (do_rd) begin
        case (sel)
          SEL_LOCK: rsp_rdata <= {{(DATA_W-1){1'b0}}, wen_q};
          SEL_ATTR: rsp_rdata <= {{(DATA_W-ATTR_W){1'b0}}, attr_q[idx]};
          default:  rsp_rdata <= '0;
        endcase
      end
      if (do_wr && sel == SEL_LOCK) begin
        wen_q <= wen_q & req_wdata[0];
      end
      if (do_wr && sel == SEL_ATTR && wen_q) begin
        attr_q[idx] <= req_wdata[ATTR_W-1:0];
      end
    end
  end

  for (genvar p = 0; p < NUM_PADS; p++) begin : g_out
    assign inv_o[p] = attr_q[p][INV_BIT];
    assign od_o[p]  = attr_q[p][OD_BIT];
  end

  // R2: once cleared the lock never comes back without reset
  a_r2_lock_sticky: assert property (@(posedge clk) disable iff (rst)
    !wen_q |=> !wen_q);

  // R2: writing one to the lock register does not change it
  a_r2_lock_one_keeps: assert property (@(posedge clk) disable iff (rst)
    (do_wr && sel == SEL_LOCK && req_wdata[0]) |=> (wen_q == $past(wen_q)));

  // R4: locked bank is frozen
  a_r4_locked_frozen: assert property (@(posedge clk) disable iff (rst)
    !wen_q |=> $stable(attr_q));

  // R5: no read, no data
  a_r5_idle_zero: assert property (@(posedge clk) disable iff (rst)
    !do_rd |=> (rsp_rdata == '0));

  // R6: error pulse follows exactly the unmapped requests
  a_r6_err_on_unmapped: assert property (@(posedge clk) disable iff (rst)
    hit_none |=> rsp_err);

  a_r6_err_only_unmapped: assert property (@(posedge clk) disable iff (rst)
    !hit_none |=> !rsp_err);

  a_r6_err_data_zero: assert property (@(posedge clk) disable iff (rst)
    rsp_err |-> (rsp_rdata == '0));
endmodule

// File: rtl/pad_attr_xform.sv
module pad_attr_xform (
  input  logic inv,
  input  logic od,
  input  logic core_out,
  input  logic core_oe,
  input  logic pad_in,
  output logic pad_out,
  output logic pad_oe,
  output logic core_in
);
  logic v;

  assign v       = core_out ^ inv;
  assign pad_out = od ? 1'b0 : v;
  assign pad_oe  = od ? (core_oe & ~v) : core_oe;
  assign core_in = pad_in ^ inv;
endmodule

// File: rtl/pad_attr_ctrl.sv
module pad_attr_ctrl
  import pad_attr_pkg::*;
#(
  parameter int NUM_FIXED = 4,
  parameter int NUM_MUXED = 18,
  parameter int ATTR_W    = 6,
  parameter int DATA_W    = 32,
  parameter int ADDR_W    = 8,
  parameter int NUM_PADS  = NUM_FIXED + NUM_MUXED
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                req_valid,
  input  logic                req_write,
  input  logic [ADDR_W-1:0]   req_addr,
  input  logic [DATA_W-1:0]   req_wdata,
  output logic [DATA_W-1:0]   rsp_rdata,
  output logic                rsp_err,
  input  logic [NUM_PADS-1:0] core_out,
  input  logic [NUM_PADS-1:0] core_oe,
  output logic [NUM_PADS-1:0] core_in,
  output logic [NUM_PADS-1:0] pad_out,
  output logic [NUM_PADS-1:0] pad_oe,
  input  logic [NUM_PADS-1:0] pad_in
);
  logic [NUM_PADS-1:0] inv_v;
  logic [NUM_PADS-1:0] od_v;

  pad_attr_regs #(
    .NUM_PADS(NUM_PADS),
    .ATTR_W  (ATTR_W),
    .DATA_W  (DATA_W),
    .ADDR_W  (ADDR_W)
  ) u_regs (
    .clk      (clk),
    .rst      (rst),
    .req_valid(req_valid),
    .req_write(req_write),
    .req_addr (req_addr),
    .req_wdata(req_wdata),
    .rsp_rdata(rsp_rdata),
    .rsp_err  (rsp_err),
    .inv_o    (inv_v),
    .od_o     (od_v)
  );

  for (genvar p = 0; p < NUM_PADS; p++) begin : g_pad
    pad_attr_xform u_xf (
      .inv     (inv_v[p]),
      .od      (od_v[p]),
      .core_out(core_out[p]),
      .core_oe (core_oe[p]),
      .pad_in  (pad_in[p]),
      .pad_out (pad_out[p]),
      .pad_oe  (pad_oe[p]),
      .core_in (core_in[p])
    );

    // R8: an open-drain pad is never driven high
    a_r8_od_no_high: assert property (@(posedge clk) disable iff (rst)
      (od_v[p] && pad_oe[p]) |-> !pad_out[p]);

    // R7: no drive without core enable
    a_r7_oe_gated: assert property (@(posedge clk) disable iff (rst)
      !core_oe[p] |-> !pad_oe[p]);
  end
endmodule

// File: tb/tb_pad_attr_ctrl.sv
module tb_pad_attr_ctrl;
  localparam int NP = 22;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          req_valid = 1'b0;
  logic          req_write = 1'b0;
  logic [7:0]    req_addr = '0;
  logic [31:0]   req_wdata = '0;
  logic [31:0]   rsp_rdata;
  logic          rsp_err;
  logic [NP-1:0] core_out = '0;
  logic [NP-1:0] core_oe = '0;
  logic [NP-1:0] core_in;
  logic [NP-1:0] pad_out;
  logic [NP-1:0] pad_oe;
  logic [NP-1:0] pad_in = '0;

  int n_tests = 0;
  int n_fail  = 0;
  logic [5:0] m_attr [NP];
  logic       m_lock;
  logic [31:0] rd_data;
  logic        rd_err;

  always #4 clk = ~clk;

  pad_attr_ctrl dut (
    .clk(clk), .rst(rst),
    .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_rdata(rsp_rdata), .rsp_err(rsp_err),
    .core_out(core_out), .core_oe(core_oe), .core_in(core_in),
    .pad_out(pad_out), .pad_oe(pad_oe), .pad_in(pad_in)
  );

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_tests++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  task automatic bus_wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0;
    rd_err = rsp_err;
  endtask

  task automatic bus_rd(input logic [7:0] a);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_addr = a; req_wdata = '0;
    @(negedge clk);
    req_valid = 1'b0;
    rd_data = rsp_rdata;
    rd_err  = rsp_err;
  endtask

  task automatic do_reset();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    for (int p = 0; p < NP; p++) m_attr[p] = '0;
    m_lock = 1'b1;
  endtask

  // compare pad vectors with the model (R7, R8, R9)
  task automatic chk_pads(input string req);
    logic [NP-1:0] e_out, e_oe, e_in;
    for (int p = 0; p < NP; p++) begin
      logic v;
      v = core_out[p] ^ m_attr[p][0];
      if (m_attr[p][1]) begin
        e_out[p] = 1'b0;
        e_oe[p]  = core_oe[p] & ~v;
      end else begin
        e_out[p] = v;
        e_oe[p]  = core_oe[p];
      end
      e_in[p] = pad_in[p] ^ m_attr[p][0];
    end
    chk({req, " pad_out"}, 32'(pad_out), 32'(e_out));
    chk({req, " pad_oe"},  32'(pad_oe),  32'(e_oe));
    chk({req, " core_in"}, 32'(core_in), 32'(e_in));
  endtask

  task automatic drive_pattern(input int j);
    for (int p = 0; p < NP; p++) begin
      core_out[p] = ((j + p) >> 0) & 1;
      core_oe[p]  = ((j + p) >> 1) & 1;
      pad_in[p]   = ((j + p) >> 2) & 1;
    end
    #1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    do_reset();
    @(negedge clk);
    // R1: reset state
    chk("R1 rdata idle", rsp_rdata, 32'h0);
    chk("R1 err idle", 32'(rsp_err), 32'h0);
    bus_rd(8'h00);
    chk("R1 lock reset", rd_data, 32'h1);
    for (int p = 0; p < NP; p++) begin
      bus_rd(8'(4 * (p + 1)));
      chk("R1 attr reset", rd_data, 32'h0);
    end
    drive_pattern(5);
    chk_pads("R1 passthrough");

    // R3 R7 R8 R10: sweep attribute combinations and pad patterns
    for (int k = 0; k < 8; k++) begin
      for (int p = 0; p < NP; p++) begin
        logic [5:0] a;
        a = 6'((k * 11 + p * 7) & 63);
        bus_wr(8'(4 * (p + 1)), {26'h3FFFFFF, a});
        m_attr[p] = a;
      end
      chk_pads("R10 effect after write");
      for (int p = 0; p < NP; p++) begin
        bus_rd(8'(4 * (p + 1)));
        chk("R3 readback", rd_data, {26'h0, m_attr[p]});
      end
      for (int j = 0; j < 8; j++) begin
        drive_pattern(j);
        chk_pads("R7 R8 sweep");
      end
    end

    // R5: data gone the cycle after a read
    bus_rd(8'h04);
    @(negedge clk);
    chk("R5 rdata cleared", rsp_rdata, 32'h0);

    // R6: unmapped and misaligned writes change nothing
    bus_wr(8'h5C, 32'h3F);
    chk("R6 err word 23", 32'(rd_err), 32'h1);
    bus_wr(8'h01, 32'h0);
    chk("R6 err misaligned", 32'(rd_err), 32'h1);
    bus_rd(8'h00);
    chk("R6 lock untouched", rd_data, 32'h1);
    bus_wr(8'h58, 32'h00);
    m_attr[21] = 6'h00;
    chk("R6 no err last pad", 32'(rd_err), 32'h0);

    // R6 R3: exhaustive offset read sweep
    for (int a = 0; a < 256; a++) begin
      logic [32:0] e;
      if ((a & 3) != 0 || (a >> 2) > NP) e = {1'b1, 32'h0};
      else if (a == 0) e = {1'b0, 31'h0, m_lock};
      else e = {1'b0, 26'h0, m_attr[(a >> 2) - 1]};
      bus_rd(8'(a));
      n_tests++;
      if ({rd_err, rd_data} !== e) begin
        n_fail++;
        $display("FAIL R6 offset %0h got=%h exp=%h", a, {rd_err, rd_data}, e);
      end
    end

    // R9: upper bits have no effect
    bus_wr(8'h10, 32'h3C);
    m_attr[3] = 6'h3C;
    for (int j = 0; j < 8; j++) begin
      drive_pattern(j);
      chk("R9 pad_out", 32'(pad_out[3]), 32'(core_out[3]));
      chk("R9 pad_oe", 32'(pad_oe[3]), 32'(core_oe[3]));
      chk("R9 core_in", 32'(core_in[3]), 32'(pad_in[3]));
    end

    // R2 R4: lock behaviour
    bus_wr(8'h00, 32'h1);
    bus_rd(8'h00);
    chk("R2 write one keeps", rd_data, 32'h1);
    bus_wr(8'h18, 32'h2A);
    m_attr[5] = 6'h2A;
    bus_wr(8'h00, 32'hFFFF_FFFE);
    m_lock = 1'b0;
    bus_rd(8'h00);
    chk("R2 cleared", rd_data, 32'h0);
    bus_wr(8'h00, 32'h1);
    bus_rd(8'h00);
    chk("R2 cannot set", rd_data, 32'h0);
    bus_wr(8'h18, 32'h15);
    chk("R4 no err", 32'(rd_err), 32'h0);
    bus_wr(8'h04, 32'h03);
    bus_rd(8'h18);
    chk("R4 locked read", rd_data, 32'h2A);
    bus_rd(8'h04);
    chk("R4 locked read pad0", rd_data, {26'h0, m_attr[0]});
    for (int j = 0; j < 8; j++) begin
      drive_pattern(j);
      chk_pads("R4 pads frozen");
    end

    // R1: reset restores the lock
    do_reset();
    bus_rd(8'h00);
    chk("R1 lock after reset", rd_data, 32'h1);
    bus_rd(8'h18);
    chk("R1 attr after reset", rd_data, 32'h0);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule